// File: doc/BRIEF.md
# Tagged Geometric-History Value Predictor

This block predicts the result value of an instruction before the instruction executes. It has two storage levels. The first is a tagless base table that is indexed by the instruction's word address. The second is a set of tagged tables. Each tagged table is indexed by the address combined with a slice of the global branch history. The slices grow geometrically from table to table. All tables are read in parallel. The matching tagged table with the longest history slice supplies the prediction, and the base table is used when no tagged table matches.

A prediction is marked usable only when the confidence counter of the supplying entry is saturated. The front end issues lookups. When the instruction completes, the back end returns the real outcome through the update port, together with the history snapshot and the provider code that the lookup reported. The block then trains the provider entry. On a wrong prediction it may also claim an entry in a table with a longer history, and it uses an internal LFSR to pick among the eligible tables.

Top module: `vp_geo_predictor`

## Requirements
- R1: After reset, every lookup reports hit 0, use 0, provider code 0 and value 0.
- R2: A lookup presented with `lk_valid_i` high is answered in the next cycle. `pred_valid_o` is high in exactly that cycle and low when no lookup was made.
- R3: The base table is indexed by the low IDX_W bits of the word address and has no tag, so two addresses that share those bits share a base entry. An update with provider code 0 to an empty base entry installs the actual value with confidence 0. It touches no tagged table.
- R4: Each entry has a 3-bit confidence counter. The counter rises by one on each correct update and stops at 7. `pred_use_o` is 1 only when the provider hits and its confidence is 7, so an entry becomes usable after installation plus seven correct updates.
- R5: A wrong update at non-zero confidence clears the confidence and keeps the stored value. A wrong update at confidence 0 replaces the stored value with the actual value.
- R6: Tagged table t (t = 1..6) uses the low 2^t history bits. Its index is the low IDX_W address bits XOR an XOR-fold of that slice to IDX_W bits. Its tag (12+t bits) is the XOR of two folds to the tag width: a fold of the address bits above the index and a fold of the history slice. The provider is the matching table with the largest t, and its provider code is t. A history that differs only in bit 0 cannot match any tagged entry.
- R7: A misprediction occurs when the provider hits with a wrong value, or when the named tagged provider entry does not match. A misprediction allocates into exactly one table above the provider whose indexed entry is empty or has usefulness 0. The new entry holds the new tag, the actual value, confidence 0 and usefulness 0.
- R8: If a misprediction finds no eligible table above the provider, it clears the usefulness flag of those upper entries and allocates nothing. A later misprediction in the same context can then allocate.
- R9: A correct update of a tagged provider sets its usefulness flag, and a wrong update clears it.
- R10: When a lookup and an update address the same entry in the same cycle, the lookup returns the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_pc_i | input | PC_W | Word address of the instruction to predict |
| lk_hist_i | input | HIST_W | Global branch history, newest outcome in bit 0 |
| pred_valid_o | output | 1 | Lookup result valid |
| pred_value_o | output | VAL_W | Predicted value |
| pred_hit_o | output | 1 | Provider entry exists |
| pred_use_o | output | 1 | Prediction confident enough to use |
| pred_provider_o | output | PROV_W | Provider code: 0 base, t for tagged table t |
| upd_valid_i | input | 1 | Update request |
| upd_pc_i | input | PC_W | Word address of the completed instruction |
| upd_hist_i | input | HIST_W | History snapshot used at lookup |
| upd_actual_i | input | VAL_W | Actual result value |
| upd_provider_i | input | PROV_W | Provider code reported at lookup |

## Verification
The embedded properties are checked on every cycle. They cover the one-cycle answer latency, that a usable prediction always comes from a hit, that at most one table allocates per update, that a base entry keeps its value when a wrong update arrives at non-zero confidence, that stored usefulness follows the write data, and that the LFSR never locks at zero. Some behaviours can only be shown by the bench's scenarios, because each needs a sequence of updates followed by a lookup. These are: the confidence threshold at exactly seven correct updates, base-index aliasing, the read-before-write result, allocation into a longer table, and the way a blocked allocation clears usefulness so that a second misprediction succeeds.

// File: rtl/vp_geo_pkg.sv
package vp_geo_pkg;

  localparam int FOLD_MAX = 64;

  // XOR-fold the low len bits of v into w bits
  function automatic logic [FOLD_MAX-1:0] fold_bits(input logic [FOLD_MAX-1:0] v,
                                                    input int len, input int w);
    logic [FOLD_MAX-1:0] r;
    r = '0;
    for (int i = 0; i < FOLD_MAX; i++) begin
      if (i < len) r[i % w] = r[i % w] ^ v[i];
    end
    return r;
  endfunction

  // history length for tagged rank g (0-based), capped at the register width
  function automatic int hist_len(input int min_h, input int g, input int max_h);
    int l;
    l = min_h << g;
    if (l > max_h) l = max_h;
    return l;
  endfunction

endpackage

// File: rtl/vp_lfsr.sv
module vp_lfsr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    TAPS = 16'hB400,
  parameter logic [W-1:0]    SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;

  always_ff @(posedge clk) begin
    if (rst) s_q <= SEED;
    else     s_q <= {s_q[W-2:0], ^(s_q & TAPS)};
  end

  assign state_o = s_q;

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) s_q != '0);
endmodule

// File: rtl/vp_base_bank.sv
module vp_base_bank #(
  parameter int IDX_W  = 6,
  parameter int VAL_W  = 64,
  parameter int CONF_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_en_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              lk_hit_o,
  output logic [CONF_W-1:0] lk_conf_o,
  output logic [VAL_W-1:0]  lk_value_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  output logic              up_valid_o,
  output logic [CONF_W-1:0] up_conf_o,
  output logic [VAL_W-1:0]  up_value_o,
  input  logic              wr_en_i,
  input  logic [CONF_W-1:0] wr_conf_i,
  input  logic [VAL_W-1:0]  wr_value_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [CONF_W-1:0] conf_mem [DEPTH];
  logic [VAL_W-1:0]  val_mem  [DEPTH];
  logic              rd_valid_q;
  logic [CONF_W-1:0] rd_conf_q;
  logic [VAL_W-1:0]  rd_val_q;

  always_ff @(posedge clk) begin
    if (rst)          valid_q <= '0;
    else if (wr_en_i) valid_q[up_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      conf_mem[up_idx_i] <= wr_conf_i;
      val_mem[up_idx_i]  <= wr_value_i;
    end
  end

  // read-first lookup port
  always_ff @(posedge clk) begin
    if (rst)          rd_valid_q <= 1'b0;
    else if (lk_en_i) rd_valid_q <= valid_q[lk_idx_i];
  end

  always_ff @(posedge clk) begin
    if (lk_en_i) begin
      rd_conf_q <= conf_mem[lk_idx_i];
      rd_val_q  <= val_mem[lk_idx_i];
    end
  end

  assign lk_hit_o   = rd_valid_q;
  assign lk_conf_o  = rd_valid_q ? rd_conf_q : '0;
  assign lk_value_o = rd_valid_q ? rd_val_q  : '0;

  assign up_valid_o = valid_q[up_idx_i];
  assign up_conf_o  = conf_mem[up_idx_i];
  assign up_value_o = val_mem[up_idx_i];

  // R5
  base_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> val_mem[$past(up_idx_i)] == $past(wr_value_i));
endmodule

// File: rtl/vp_tag_bank.sv
module vp_tag_bank #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 13,
  parameter int VAL_W  = 64,
  parameter int CONF_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_en_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  output logic              lk_hit_o,
  output logic [CONF_W-1:0] lk_conf_o,
  output logic [VAL_W-1:0]  lk_value_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  output logic              up_valid_o,
  output logic [TAG_W-1:0]  up_tag_o,
  output logic              up_u_o,
  output logic [CONF_W-1:0] up_conf_o,
  output logic [VAL_W-1:0]  up_value_o,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_u_i,
  input  logic [CONF_W-1:0] wr_conf_i,
  input  logic [VAL_W-1:0]  wr_value_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic              u_mem    [DEPTH];
  logic [CONF_W-1:0] conf_mem [DEPTH];
  logic [VAL_W-1:0]  val_mem  [DEPTH];
  logic              rd_valid_q;
  logic [TAG_W-1:0]  rd_tag_q, req_tag_q;
  logic [CONF_W-1:0] rd_conf_q;
  logic [VAL_W-1:0]  rd_val_q;

  always_ff @(posedge clk) begin
    if (rst)          valid_q <= '0;
    else if (wr_en_i) valid_q[up_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      tag_mem[up_idx_i]  <= wr_tag_i;
      u_mem[up_idx_i]    <= wr_u_i;
      conf_mem[up_idx_i] <= wr_conf_i;
      val_mem[up_idx_i]  <= wr_value_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_valid_q <= 1'b0;
    else if (lk_en_i) rd_valid_q <= valid_q[lk_idx_i];
  end

  always_ff @(posedge clk) begin
    if (lk_en_i) begin
      rd_tag_q  <= tag_mem[lk_idx_i];
      rd_conf_q <= conf_mem[lk_idx_i];
      rd_val_q  <= val_mem[lk_idx_i];
      req_tag_q <= lk_tag_i;
    end
  end

  assign lk_hit_o   = rd_valid_q && (rd_tag_q == req_tag_q);
  assign lk_conf_o  = rd_conf_q;
  assign lk_value_o = rd_val_q;

  assign up_valid_o = valid_q[up_idx_i];
  assign up_tag_o   = tag_mem[up_idx_i];
  assign up_u_o     = u_mem[up_idx_i];
  assign up_conf_o  = conf_mem[up_idx_i];
  assign up_value_o = val_mem[up_idx_i];

  // R9
  useful_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |=> u_mem[$past(up_idx_i)] == $past(wr_u_i));
endmodule

// File: rtl/vp_geo_predictor.sv
module vp_geo_predictor #(
  parameter int          PC_W       = 30,
  parameter int          HIST_W     = 64,
  parameter int          VAL_W      = 64,
  parameter int          IDX_W      = 6,
  parameter int          NUM_TAGGED = 6,
  parameter int          MIN_HIST   = 2,
  parameter int          TAG_BASE   = 12,
  parameter int          CONF_W     = 3,
  parameter logic [15:0] LFSR_SEED  = 16'hACE1,
  localparam int         PROV_W     = $clog2(NUM_TAGGED + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid_i,
  input  logic [PC_W-1:0]   lk_pc_i,
  input  logic [HIST_W-1:0] lk_hist_i,
  output logic              pred_valid_o,
  output logic [VAL_W-1:0]  pred_value_o,
  output logic              pred_hit_o,
  output logic              pred_use_o,
  output logic [PROV_W-1:0] pred_provider_o,
  input  logic              upd_valid_i,
  input  logic [PC_W-1:0]   upd_pc_i,
  input  logic [HIST_W-1:0] upd_hist_i,
  input  logic [VAL_W-1:0]  upd_actual_i,
  input  logic [PROV_W-1:0] upd_provider_i
);
  import vp_geo_pkg::*;

  localparam int                NT       = NUM_TAGGED;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam int                UPPER_W  = PC_W - IDX_W;

  logic [FOLD_MAX-1:0] lk_h64, up_h64, lk_pc_hi, up_pc_hi;
  assign lk_h64   = FOLD_MAX'(lk_hist_i);
  assign up_h64   = FOLD_MAX'(upd_hist_i);
  assign lk_pc_hi = FOLD_MAX'(lk_pc_i >> IDX_W);
  assign up_pc_hi = FOLD_MAX'(upd_pc_i >> IDX_W);

  // ---------------- per-table signals ----------------
  logic [NT-1:0]     lk_hit, up_valid, up_u, up_match;
  logic [CONF_W-1:0] lk_conf [NT];
  logic [VAL_W-1:0]  lk_val  [NT];
  logic [CONF_W-1:0] up_conf [NT];
  logic [VAL_W-1:0]  up_val  [NT];
  logic [NT-1:0]     wr_en, wr_u, wr_new, train, cand, alloc_vec;
  logic [CONF_W-1:0] wr_conf [NT];
  logic [VAL_W-1:0]  wr_val  [NT];

  // ---------------- base table ----------------
  logic              b_lk_hit, b_up_valid, b_wr_en;
  logic [CONF_W-1:0] b_lk_conf, b_up_conf, b_wr_conf;
  logic [VAL_W-1:0]  b_lk_val, b_up_val, b_wr_val;

  vp_base_bank #(.IDX_W(IDX_W), .VAL_W(VAL_W), .CONF_W(CONF_W)) base_i (
    .clk, .rst,
    .lk_en_i(lk_valid_i), .lk_idx_i(lk_pc_i[IDX_W-1:0]),
    .lk_hit_o(b_lk_hit), .lk_conf_o(b_lk_conf), .lk_value_o(b_lk_val),
    .up_idx_i(upd_pc_i[IDX_W-1:0]),
    .up_valid_o(b_up_valid), .up_conf_o(b_up_conf), .up_value_o(b_up_val),
    .wr_en_i(b_wr_en), .wr_conf_i(b_wr_conf), .wr_value_i(b_wr_val)
  );

  // ---------------- tagged tables ----------------
  for (genvar g = 0; g < NT; g++) begin : g_tbl
    localparam int TW = TAG_BASE + g + 1;
    localparam int HL = hist_len(MIN_HIST, g, HIST_W);

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TW-1:0]    lk_tag, up_tag, st_tag;

    assign lk_idx = lk_pc_i[IDX_W-1:0] ^ IDX_W'(fold_bits(lk_h64, HL, IDX_W));
    assign up_idx = upd_pc_i[IDX_W-1:0] ^ IDX_W'(fold_bits(up_h64, HL, IDX_W));
    assign lk_tag = TW'(fold_bits(lk_pc_hi, UPPER_W, TW) ^ fold_bits(lk_h64, HL, TW));
    assign up_tag = TW'(fold_bits(up_pc_hi, UPPER_W, TW) ^ fold_bits(up_h64, HL, TW));
    assign up_match[g] = up_valid[g] && (st_tag == up_tag);

    vp_tag_bank #(.IDX_W(IDX_W), .TAG_W(TW), .VAL_W(VAL_W), .CONF_W(CONF_W)) bank_i (
      .clk, .rst,
      .lk_en_i(lk_valid_i), .lk_idx_i(lk_idx), .lk_tag_i(lk_tag),
      .lk_hit_o(lk_hit[g]), .lk_conf_o(lk_conf[g]), .lk_value_o(lk_val[g]),
      .up_idx_i(up_idx), .up_valid_o(up_valid[g]), .up_tag_o(st_tag),
      .up_u_o(up_u[g]), .up_conf_o(up_conf[g]), .up_value_o(up_val[g]),
      .wr_en_i(wr_en[g]), .wr_tag_i(wr_new[g] ? up_tag : st_tag),
      .wr_u_i(wr_u[g]), .wr_conf_i(wr_conf[g]), .wr_value_i(wr_val[g])
    );
  end

  // ---------------- random table choice ----------------
  logic [15:0] lfsr_q;
  vp_lfsr #(.W(16), .TAPS(16'hB400), .SEED(LFSR_SEED)) lfsr_i (
    .clk, .rst, .state_o(lfsr_q)
  );

  // ---------------- lookup result ----------------
  logic pred_valid_q;
  always_ff @(posedge clk) begin
    if (rst) pred_valid_q <= 1'b0;
    else     pred_valid_q <= lk_valid_i;
  end

  logic [CONF_W-1:0] sel_conf;
  always_comb begin
    pred_provider_o = '0;
    pred_value_o    = b_lk_val;
    sel_conf        = b_lk_conf;
    pred_hit_o      = b_lk_hit;
    for (int t = 0; t < NT; t++) begin
      if (lk_hit[t]) begin
        pred_provider_o = PROV_W'(t + 1);
        pred_value_o    = lk_val[t];
        sel_conf        = lk_conf[t];
        pred_hit_o      = 1'b1;
      end
    end
    pred_use_o = pred_hit_o && (sel_conf == CONF_MAX);
  end

  assign pred_valid_o = pred_valid_q;

  // ---------------- update / train / allocate ----------------
  logic              prov_hit, correct, mispred, found;
  logic [CONF_W-1:0] prov_conf;
  logic [VAL_W-1:0]  prov_val;
  int                pidx, start, j;

  always_comb begin
    pidx      = int'(upd_provider_i);
    prov_hit  = (pidx == 0) && b_up_valid;
    prov_conf = b_up_conf;
    prov_val  = b_up_val;
    for (int t = 0; t < NT; t++) begin
      if (pidx == t + 1) begin
        prov_hit  = up_match[t];
        prov_conf = up_conf[t];
        prov_val  = up_val[t];
      end
    end
    correct = prov_hit && (prov_val == upd_actual_i);
    mispred = upd_valid_i && !correct && !((pidx == 0) && !b_up_valid);

    // base training
    b_wr_en   = upd_valid_i && (pidx == 0);
    b_wr_conf = '0;
    b_wr_val  = b_up_val;
    if (!b_up_valid) begin
      b_wr_val = upd_actual_i;
    end else if (correct) begin
      b_wr_conf = (b_up_conf == CONF_MAX) ? b_up_conf : b_up_conf + 1'b1;
    end else if (b_up_conf == '0) begin
      b_wr_val = upd_actual_i;
    end

    // candidates above the provider
    for (int t = 0; t < NT; t++) begin
      train[t] = upd_valid_i && (pidx == t + 1) && up_match[t];
      cand[t]  = mispred && (t >= pidx) && (!up_valid[t] || !up_u[t]);
    end

    start     = int'(lfsr_q) % NT;
    found     = 1'b0;
    alloc_vec = '0;
    j         = 0;
    for (int k = 0; k < NT; k++) begin
      j = (start + k) % NT;
      if (!found && cand[j]) begin
        alloc_vec[j] = 1'b1;
        found        = 1'b1;
      end
    end

    for (int t = 0; t < NT; t++) begin
      wr_new[t]  = alloc_vec[t];
      wr_u[t]    = train[t] && correct;
      wr_en[t]   = train[t] || alloc_vec[t] ||
                   (mispred && !found && (t >= pidx) && up_valid[t]);
      wr_conf[t] = up_conf[t];
      wr_val[t]  = up_val[t];
      if (alloc_vec[t]) begin
        wr_conf[t] = '0;
        wr_val[t]  = upd_actual_i;
      end else if (train[t]) begin
        if (correct) begin
          wr_conf[t] = (up_conf[t] == CONF_MAX) ? up_conf[t] : up_conf[t] + 1'b1;
        end else begin
          wr_conf[t] = '0;
          if (up_conf[t] == '0) wr_val[t] = upd_actual_i;
        end
      end
    end
  end

  // R2
  lookup_latency_chk: assert property (@(posedge clk) disable iff (rst)
    lk_valid_i |=> pred_valid_o);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !lk_valid_i |=> !pred_valid_o);
  // R4
  use_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
    pred_use_o |-> pred_hit_o);
  // R7
  single_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(alloc_vec));
  // R7
  alloc_needs_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (|alloc_vec) |-> (upd_valid_i && !correct));
  // R5
  base_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (b_wr_en && b_up_valid && b_up_conf != '0) |-> (b_wr_val == b_up_val));
endmodule

// File: tb/vp_geo_predictor_tb.sv
`timescale 1ns/1ps
module vp_geo_predictor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [29:0] lk_pc = '0;
  logic [63:0] lk_hist = '0;
  logic        pred_valid, pred_hit, pred_use;
  logic [63:0] pred_value;
  logic [2:0]  pred_provider;
  logic        upd_valid = 1'b0;
  logic [29:0] upd_pc = '0;
  logic [63:0] upd_hist = '0;
  logic [63:0] upd_actual = '0;
  logic [2:0]  upd_provider = '0;

  int n_checks = 0;
  int n_err = 0;

  logic        r_valid, r_hit, r_use;
  logic [63:0] r_value;
  logic [2:0]  r_prov;

  always #2 clk = ~clk;

  vp_geo_predictor dut_i (
    .clk, .rst,
    .lk_valid_i(lk_valid), .lk_pc_i(lk_pc), .lk_hist_i(lk_hist),
    .pred_valid_o(pred_valid), .pred_value_o(pred_value), .pred_hit_o(pred_hit),
    .pred_use_o(pred_use), .pred_provider_o(pred_provider),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_hist_i(upd_hist),
    .upd_actual_i(upd_actual), .upd_provider_i(upd_provider)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic grab();
    r_valid = pred_valid; r_hit = pred_hit; r_use = pred_use;
    r_value = pred_value; r_prov = pred_provider;
  endtask

  task automatic lookup(input logic [29:0] pc, input logic [63:0] h);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_hist = h;
    @(negedge clk);
    lk_valid = 1'b0;
    grab();
  endtask

  task automatic update(input logic [29:0] pc, input logic [63:0] h,
                        input logic [2:0] prov, input logic [63:0] act);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_provider = prov; upd_actual = act;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic both(input logic [29:0] pc, input logic [63:0] h,
                      input logic [2:0] prov, input logic [63:0] act);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc; lk_hist = h;
    upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_provider = prov; upd_actual = act;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    grab();
  endtask

  localparam logic [29:0] P1 = 30'h0000_1001;
  localparam logic [29:0] P2 = 30'h0000_2002;
  localparam logic [63:0] H1 = 64'h1234_5678_9ABC_DEF0;
  localparam logic [63:0] H3 = 64'hFEDC_BA98_7654_3211;
  localparam logic [63:0] V1 = 64'hAAAA_0000_1111_2222;
  localparam logic [63:0] V2 = 64'hBBBB_3333_4444_5555;
  localparam logic [63:0] V3 = 64'hCCCC_6666_7777_8888;

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    logic [63:0] x;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    lookup(P1, H1);
    chk("R1", "hit", 64'(r_hit), 64'd0);
    chk("R1", "use", 64'(r_use), 64'd0);
    chk("R1", "provider", 64'(r_prov), 64'd0);
    chk("R1", "value", r_value, 64'd0);
    // R2 valid timing
    chk("R2", "valid after lookup", 64'(r_valid), 64'd1);
    @(negedge clk);
    chk("R2", "valid when idle", 64'(pred_valid), 64'd0);

    // R3 base install and aliasing
    update(P1, H1, 3'd0, V1);
    lookup(P1, H1 ^ 64'd1);
    chk("R3", "base value", r_value, V1);
    chk("R3", "base hit", 64'(r_hit), 64'd1);
    chk("R3", "base use", 64'(r_use), 64'd0);
    lookup(P1 + 30'd64, H1 ^ 64'd1);
    chk("R3", "alias value", r_value, V1);
    lookup(P1, H1);
    chk("R3", "no tagged alloc on install", 64'(r_prov), 64'd0);

    // R4 confidence ramp, R10 read-first
    for (int i = 0; i < 6; i++) update(P1, H1, 3'd0, V1);
    lookup(P1, H1);
    chk("R4", "use at conf 6", 64'(r_use), 64'd0);
    both(P1, H1, 3'd0, V1);
    chk("R10", "pre-update use", 64'(r_use), 64'd0);
    lookup(P1, H1);
    chk("R4", "use at conf 7", 64'(r_use), 64'd1);
    update(P1, H1, 3'd0, V1);
    lookup(P1, H1);
    chk("R4", "use stays saturated", 64'(r_use), 64'd1);

    // R5 wrong at conf 7 keeps value; R7 allocation above base
    update(P1, H1, 3'd0, V2);
    lookup(P1, H1 ^ 64'd1);
    chk("R5", "value kept", r_value, V1);
    chk("R5", "use dropped", 64'(r_use), 64'd0);
    chk("R6", "bit0 history misses tagged", 64'(r_prov), 64'd0);
    lookup(P1, H1);
    chk("R7", "provider above base", 64'(r_prov != 3'd0 && r_prov <= 3'd6), 64'd1);
    chk("R7", "allocated value", r_value, V2);
    chk("R7", "allocated use", 64'(r_use), 64'd0);
    chk("R7", "allocated hit", 64'(r_hit), 64'd1);
    // R5 wrong at conf 0 replaces
    update(P1, H1 ^ 64'd1, 3'd0, V3);
    lookup(P1, H1 ^ 64'd2);
    chk("R5", "value replaced", r_value, V3);
    chk("R5", "provider base", 64'(r_prov), 64'd0);

    // R8 / R9 blocked allocation
    update(P2, H3, 3'd0, 64'h10);
    update(P2, H3, 3'd5, 64'h11);
    lookup(P2, H3);
    chk("R6", "longest provider", 64'(r_prov), 64'd6);
    chk("R7", "new entry value", r_value, 64'h11);
    for (int i = 0; i < 7; i++) update(P2, H3, 3'd6, 64'h11);
    lookup(P2, H3);
    chk("R9", "trained use", 64'(r_use), 64'd1);
    update(P2, H3, 3'd5, 64'h12);
    lookup(P2, H3);
    chk("R8", "no alloc value", r_value, 64'h11);
    chk("R8", "no alloc use", 64'(r_use), 64'd1);
    update(P2, H3, 3'd5, 64'h13);
    lookup(P2, H3);
    chk("R8", "alloc after clear value", r_value, 64'h13);
    chk("R8", "alloc after clear use", 64'(r_use), 64'd0);
    chk("R8", "alloc after clear provider", 64'(r_prov), 64'd6);

    // random base training
    for (int i = 0; i < 24; i++) begin
      logic [29:0] pc;
      logic [63:0] h;
      int k;
      pc = {24'($urandom), 6'(8 + i)};
      h  = {$urandom, $urandom};
      x  = {$urandom, $urandom};
      k  = int'($urandom % 10);
      update(pc, h, 3'd0, x);
      for (int n = 0; n < k; n++) update(pc, h, 3'd0, x);
      lookup(pc, h);
      chk("R4", "random use", 64'(r_use), 64'(k >= 7));
      chk("R3", "random value", r_value, x);
      chk("R3", "random provider", 64'(r_prov), 64'd0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule